// File: doc/BRIEF.md
# Prescaled Down-Counting Capture Timer

This block is a free-running 16-bit down counter whose decrement rate is set by an 8-bit programmable prescaler. Each time the chosen transition appears on a single external capture pin, the counter's value is copied into a capture register. Software talks to the block through a small byte-wide register interface. Through it, software sets the divide ratio, starts or stops the timer, writes the counter, picks the capture edge, reads the counter and capture values, and manages two interrupt sources.

Two measurements are typical. The interval between two like edges is taken from two captures on the same edge, and their difference is the period in counter ticks. A pulse width is measured by capturing on one edge and then switching the edge select, so that the next capture lands on the opposite transition. Because the counter runs downward, an earlier capture holds the larger value, and the width is the first capture minus the second.

Top module: `cap_timer`

## Requirements
- R1: After reset, all registers read zero and `irq_o` is low. Registers are CTRL at 0x0, STAT at 0x1, the prescale value at 0x2, the counter at 0x4 (low byte) and 0x5 (high byte), and the capture register at 0x6 (low byte) and 0x7 (high byte).
- R2: While CTRL bit 0 (run) is 1 and the prescale register holds N, the counter decrements exactly once every N+1 clocks.
- R3: While run is 0, the counter and the prescaler hold their values.
- R4: Writing 0x4 or 0x5 replaces that byte of the counter. A write takes priority over a decrement in the same cycle.
- R5: A decrement from 0x0000 wraps the counter to 0xFFFF and sets the underflow pending flag, STAT bit 1.
- R6: CTRL bit 1 selects the capture edge: 0 selects rising and 1 selects falling. On the selected transition of `cap_pin_i`, the counter value is copied into the capture register two to three clocks after the pin changes, and the capture pending flag, STAT bit 0, is set. This also happens while the timer is stopped. The opposite transition neither captures nor sets the flag.
- R7: Writes to 0x6 and 0x7 have no effect on the capture register.
- R8: `irq_o` is high exactly when one of these holds: capture pending with CTRL bit 2 set, or underflow pending with CTRL bit 3 set.
- R9: Writing 1 to a STAT bit clears that pending flag. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: The edge select may be changed between captures without producing a spurious capture. The difference between a capture on the rising edge and a later capture on the falling edge equals the pulse width in counter ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, combinational from `addr_i` |
| cap_pin_i | input | 1 | Asynchronous capture input |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times a pulse whose edges are a known number of clocks apart under a non-unity prescale. A design with unequal latencies for rising and falling captures, or one that fires on the switch of the edge select, returns a wrong width. The wrap from zero is checked through both the pending flag and the high byte, which catches a counter that saturates or a flag that is tied to the wrong source. Captures are tested while the timer is stopped, on the ignored edge, and after writes to the read-only capture address, to catch an edge detector of the wrong polarity or a capture register that the bus can overwrite. Pending clears are written with both 0 and 1 to catch a flag that clears on any write.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h4;

  typedef struct packed {
    logic unf_ie;
    logic cap_ie;
    logic edge_fall;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  logic lvl, prev;
  assign lvl  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
  assign evt_o = fall_sel_i ? (prev & ~lvl) : (lvl & ~prev);
endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         reload_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (reload_i)     cnt_q <= div_i;
    else if (run_i) begin
      if (cnt_q == '0)     cnt_q <= div_i;
      else                 cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/cap_down_counter.sv
module cap_down_counter #(
  parameter int unsigned W     = 16,
  parameter int unsigned LANES = W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic [LANES-1:0] wr_lane_i,
  input  logic [7:0]       wr_byte_i,
  output logic [W-1:0]     cnt_o,
  output logic             unf_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign unf_o = dec_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (dec_i) cnt_d = cnt_q - W'(1);
    for (int l = 0; l < int'(LANES); l++) begin
      if (wr_lane_i[l]) cnt_d[l*8 +: 8] = wr_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PSC_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  input  logic              cap_pin_i,
  output logic              irq_o
);
  localparam int unsigned LANES = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(int'(A_CNT) + int'(LANES));

  ctrl_t              ctrl_q;
  logic [PSC_W-1:0]   psc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cap_q;
  logic               cap_pend_q, unf_pend_q;
  logic               psc_tick, cap_evt, unf_evt;
  logic [LANES-1:0]   cnt_lane_wr;
  logic               wr_ctrl, wr_stat, wr_psc;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_psc  = wr_en_i && (addr_i == A_PSC);

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    assign cnt_lane_wr[l] = wr_en_i && (addr_i == ADDR_W'(int'(A_CNT) + l));
  end

  cap_prescaler #(.W(PSC_W)) i_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .reload_i (wr_psc),
    .div_i    (wr_psc ? wr_data_i[PSC_W-1:0] : psc_q),
    .tick_o   (psc_tick)
  );

  cap_down_counter #(.W(CNT_W), .LANES(LANES)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (psc_tick),
    .wr_lane_i (cnt_lane_wr),
    .wr_byte_i (wr_data_i),
    .cnt_o     (cnt_q),
    .unf_o     (unf_evt)
  );

  cap_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (cap_pin_i),
    .fall_sel_i (ctrl_q.edge_fall),
    .evt_o      (cap_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      psc_q      <= '0;
      cap_q      <= '0;
      cap_pend_q <= 1'b0;
      unf_pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[3:0]);
      if (wr_psc)  psc_q  <= wr_data_i[PSC_W-1:0];
      if (cap_evt) cap_q  <= cnt_q;
      // set wins over write-one-to-clear
      cap_pend_q <= cap_evt | (cap_pend_q & ~(wr_stat & wr_data_i[0]));
      unf_pend_q <= unf_evt | (unf_pend_q & ~(wr_stat & wr_data_i[1]));
    end
  end

  assign irq_o = (cap_pend_q & ctrl_q.cap_ie) | (unf_pend_q & ctrl_q.unf_ie);

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_CTRL) rd_data_o = BUS_W'(ctrl_q);
    if (addr_i == A_STAT) rd_data_o = BUS_W'({unf_pend_q, cap_pend_q});
    if (addr_i == A_PSC)  rd_data_o = BUS_W'(psc_q);
    for (int l = 0; l < int'(LANES); l++) begin
      if (addr_i == ADDR_W'(int'(A_CNT) + l)) rd_data_o = cnt_q[l*8 +: 8];
      if (addr_i == ADDR_W'(int'(A_CAP) + l)) rd_data_o = cap_q[l*8 +: 8];
    end
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              run_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              cap_evt_i,
  input logic [CNT_W-1:0]  cap_i,
  input logic              cap_pend_i,
  input logic              unf_pend_i,
  input logic              irq_i
);
  localparam int unsigned LANES = CNT_W / 8;
  logic cnt_wr;
  assign cnt_wr = wr_en_i && (int'(addr_i) >= int'(A_CNT)) &&
                  (int'(addr_i) < int'(A_CNT) + int'(LANES));

  a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr) |=> $stable(cnt_i));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i != '0 && !cnt_wr) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  a_r5_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '0 && !cnt_wr) |=> (cnt_i == '1 && unf_pend_i));

  a_r6_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> (cap_i == $past(cnt_i) && cap_pend_i));

  a_r7_capture_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_evt_i |=> $stable(cap_i));

  a_r8_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_pend_i && !unf_pend_i) |-> !irq_i);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) i_cap_timer_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .run_i      (ctrl_q.run),
  .tick_i     (psc_tick),
  .cnt_i      (cnt_q),
  .cap_evt_i  (cap_evt),
  .cap_i      (cap_q),
  .cap_pend_i (cap_pend_q),
  .unf_pend_i (unf_pend_q),
  .irq_i      (irq_o)
);

// File: tb/test_cap_timer.sv
`timescale 1ns/1ps
module test_cap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pin = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { string tag; int unsigned val; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  cap_timer i_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .cap_pin_i(pin), .irq_o(irq)
  );

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input string tag, input int unsigned v);
    exp_t e;
    e.tag = tag; e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor side of the scoreboard
  task automatic pop_cmp(input int unsigned act);
    exp_t e;
    if (exp_q.size() == 0) begin
      check("scoreboard empty", act, 32'hFFFF_FFFF);
    end else begin
      e = exp_q.pop_front();
      check(e.tag, act, e.val);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, b); check("R1 ctrl", b, 0);
    rd(4'h1, b); check("R1 stat", b, 0);
    rd(4'h2, b); check("R1 prescale", b, 0);
    rd16(4'h4, c0); check("R1 counter", c0, 0);
    rd16(4'h6, c0); check("R1 capture", c0, 0);
    check("R1 irq", irq, 0);

    // R4 byte writes, R3 hold while stopped
    wr(4'h5, 8'h12); wr(4'h4, 8'h34);
    rd16(4'h4, c0); check("R4 counter write", c0, 16'h1234);
    repeat (10) @(negedge clk);
    rd16(4'h4, c0); check("R3 stopped hold", c0, 16'h1234);

    // R2 prescale 0
    wr(4'h0, 8'h01);
    rd16(4'h4, c0); repeat (20) @(negedge clk); rd16(4'h4, c1);
    check("R2 rate N=0", 16'(c0 - c1), 20);
    // R2 prescale 3
    wr(4'h2, 8'h03);
    rd16(4'h4, c0); repeat (40) @(negedge clk); rd16(4'h4, c1);
    check("R2 rate N=3", 16'(c0 - c1), 10);
    wr(4'h0, 8'h00);
    rd16(4'h4, c0); repeat (12) @(negedge clk); rd16(4'h4, c1);
    check("R3 stop holds", c1, c0);

    // R5 underflow wrap
    wr(4'h2, 8'h00); wr(4'h4, 8'h02); wr(4'h5, 8'h00);
    rd(4'h1, b); check("R5 no flag before wrap", b, 0);
    wr(4'h0, 8'h09);
    repeat (6) @(negedge clk);
    wr(4'h0, 8'h08);
    rd(4'h1, b); check("R5 underflow flag", b, 2);
    rd(4'h5, b); check("R5 wrapped high byte", b, 8'hFF);
    check("R8 irq on underflow", irq, 1);
    // R9 clears
    wr(4'h1, 8'h00);
    rd(4'h1, b); check("R9 write 0 keeps", b, 2);
    wr(4'h1, 8'h02);
    rd(4'h1, b); check("R9 write 1 clears", b, 0);
    check("R8 irq after clear", irq, 0);

    // R6 rising capture while stopped
    wr(4'h0, 8'h00); wr(4'h4, 8'hCD); wr(4'h5, 8'hAB);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    push_exp("R6 rising capture", 16'hABCD);
    rd16(4'h6, c0); pop_cmp(c0);
    rd(4'h1, b); check("R6 capture flag", b, 1);
    check("R8 irq masked", irq, 0);
    wr(4'h0, 8'h04);
    check("R8 irq enabled", irq, 1);
    wr(4'h1, 8'h01);
    check("R9 capture clear", irq, 0);
    // opposite edge ignored
    wr(4'h4, 8'h11); wr(4'h5, 8'h11);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    rd16(4'h6, c0); check("R6 falling ignored value", c0, 16'hABCD);
    rd(4'h1, b); check("R6 falling ignored flag", b, 0);
    // R7 read-only capture
    wr(4'h6, 8'h55); wr(4'h7, 8'h66);
    rd16(4'h6, c0); check("R7 capture read-only", c0, 16'hABCD);

    // R6 falling-edge mode
    wr(4'h0, 8'h02); wr(4'h4, 8'h22); wr(4'h5, 8'h22);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'h1, b); check("R6 rising ignored in fall mode", b, 0);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    push_exp("R6 falling capture", 16'h2222);
    rd16(4'h6, c0); pop_cmp(c0);
    wr(4'h1, 8'h01);

    // R10 pulse width, prescale 1, 60 clocks high -> 30 ticks
    wr(4'h2, 8'h01); wr(4'h0, 8'h01);
    pin = 1'b1;
    repeat (5) @(negedge clk);
    rd16(4'h6, c0);
    wr(4'h1, 8'h01);
    wr(4'h0, 8'h03);
    rd(4'h1, b); check("R10 no capture on edge switch", b, 0);
    repeat (53) @(negedge clk);
    pin = 1'b0;
    repeat (5) @(negedge clk);
    rd16(4'h6, c1);
    push_exp("R10 pulse width", 30);
    pop_cmp(16'(c0 - c1));
    rd(4'h1, b); check("R10 second capture flag", b, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule